// File: doc/BRIEF.md
# Threshold-Request Audio FIFO

This block holds audio samples for one stream direction in a small synchronous first-in-first-out store of 32-bit words. A producer pushes words through a valid/ready write port, and a consumer pops them through a valid/ready read port. The block reports how many words it holds.

The fill level is compared against three programmable thresholds. Each comparison has its own enable and drives its own request line: one interrupt request and two DMA request channels. The compare sense is chosen at build time by a direction parameter:

- A receive-side instance asks to be drained when the level is high enough.
- A transmit-side instance asks to be refilled when the level is low enough.

A packed status vector mirrors the three request lines. A synchronous flush input discards all content. Illegal accesses are dropped and flagged with a one-cycle error pulse.

Top module: `audio_fifo_req`

## Requirements
- R1: After reset, the level is 0, write ready is 1, read valid is 0 and the error output is 0.
- R2: Words leave in the order they were accepted, and read data shows the oldest stored word whenever read valid is 1.
- R3: The level equals accepted writes minus accepted reads and stays within 0 to DEPTH (8). Write ready is low exactly when the level is DEPTH, and read valid is high exactly when the level is nonzero.
- R4: A write attempted while full is dropped: the level and the contents are unchanged. The error output goes high for exactly the next cycle.
- R5: A read attempted while empty is dropped, and the error output goes high for exactly the next cycle.
- R6: With the direction parameter at 1 (receive), each request is high while its enable is 1 and the level is greater than or equal to its threshold.
- R7: With the direction parameter at 0 (transmit), each request is high while its enable is 1 and the level is less than or equal to its threshold.
- R8: A request whose enable is 0 is low at every level.
- R9: The status vector holds the interrupt request in bit 0, DMA channel 1 in bit 1 and DMA channel 2 in bit 2.
- R10: A flush empties the FIFO in one cycle, overrides any write or read offered in the same cycle, and raises no error. The next word written is the next word read.
- R11: A write and a read accepted in the same cycle leave the level unchanged and keep the order of the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all stored words |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Word offered |
| wr_ready | output | 1 | FIFO can accept a word |
| rd_valid | output | 1 | FIFO holds a word |
| rd_data | output | DATA_W | Oldest stored word |
| rd_ready | input | 1 | Consumer takes the word |
| level | output | LW | Words currently held |
| irq_en | input | 1 | Interrupt request enable |
| dma1_en | input | 1 | DMA channel 1 request enable |
| dma2_en | input | 1 | DMA channel 2 request enable |
| irq_thr | input | LW | Interrupt threshold |
| dma1_thr | input | LW | DMA channel 1 threshold |
| dma2_thr | input | LW | DMA channel 2 threshold |
| irq_req | output | 1 | Interrupt request |
| dma1_req | output | 1 | DMA channel 1 request |
| dma2_req | output | 1 | DMA channel 2 request |
| req_status | output | 3 | {dma2, dma1, irq} request image |
| err | output | 1 | Dropped-access pulse |

## Verification
The bench pushes one word past full and pulls one word from an empty store.

- A design that lets the overflow word in would corrupt the level or overwrite the oldest sample.
- A design that lets the underflow read through would wrap the level to 15.

Both a receive instance and a transmit instance see every level from 0 to 8 with thresholds at 0, mid-range and 8. An off-by-one or inverted comparator would therefore assert a request one level early or on the wrong side. Flushing while a write and a read are offered catches a flush that loses priority or leaves the pointers misaligned.

// File: rtl/audio_fifo_req.sv
module audio_fifo_req #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter bit IS_RX  = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic [LW-1:0]     level,
  input  logic              irq_en,
  input  logic              dma1_en,
  input  logic              dma2_en,
  input  logic [LW-1:0]     irq_thr,
  input  logic [LW-1:0]     dma1_thr,
  input  logic [LW-1:0]     dma2_thr,
  output logic              irq_req,
  output logic              dma1_req,
  output logic              dma2_req,
  output logic [2:0]        req_status,
  output logic              err
);

  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              wr_ok, rd_ok;

  assign wr_ready = (level != FULL_LVL);
  assign rd_valid = (level != '0);
  assign wr_ok    = wr_valid && wr_ready && !flush;
  assign rd_ok    = rd_ready && rd_valid && !flush;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      err   <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      if (wr_ok && !rd_ok)      level <= level + 1'b1;
      else if (rd_ok && !wr_ok) level <= level - 1'b1;
      err <= (wr_valid && !wr_ready) || (rd_ready && !rd_valid);
    end
  end

  logic [2:0]    en_v;
  logic [LW-1:0] thr_v [3];
  logic [2:0]    hit;

  assign en_v     = {dma2_en, dma1_en, irq_en};
  assign thr_v[0] = irq_thr;
  assign thr_v[1] = dma1_thr;
  assign thr_v[2] = dma2_thr;

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    if (IS_RX) begin : g_rx
      assign hit[i] = en_v[i] && (level >= thr_v[i]);
    end else begin : g_tx
      assign hit[i] = en_v[i] && (level <= thr_v[i]);
    end
  end

  assign irq_req    = hit[0];
  assign dma1_req   = hit[1];
  assign dma2_req   = hit[2];
  assign req_status = hit;

  p_level_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !rd_ready && !flush) |=> (err && level == FULL_LVL));
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !flush) |=> err);
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);
  p_dma1_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma1_en |-> !dma1_req);
  p_dma2_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma2_en |-> !dma2_req);
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !err));
  p_same_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_ready && rd_valid && !flush) |=> $stable(level));

endmodule

// File: tb/tb_audio_fifo_req.sv
module tb_audio_fifo_req;
  localparam int DW = 32;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n, flush, wr_valid, rd_ready;
  logic [DW-1:0] wr_data;
  logic irq_en, dma1_en, dma2_en;
  logic [LW-1:0] irq_thr, dma1_thr, dma2_thr;

  logic wr_ready, rd_valid, err, irq_req, dma1_req, dma2_req;
  logic [DW-1:0] rd_data;
  logic [LW-1:0] level;
  logic [2:0] req_status;

  logic t_wr_ready, t_rd_valid, t_err, t_irq, t_dma1, t_dma2;
  logic [DW-1:0] t_rd_data;
  logic [LW-1:0] t_level;
  logic [2:0] t_status;

  int n_checks = 0;
  int n_errs = 0;
  logic [DW-1:0] q[$];
  logic exp_err;

  always #10 clk = ~clk;

  audio_fifo_req #(.IS_RX(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .level(level), .irq_en(irq_en), .dma1_en(dma1_en), .dma2_en(dma2_en),
    .irq_thr(irq_thr), .dma1_thr(dma1_thr), .dma2_thr(dma2_thr),
    .irq_req(irq_req), .dma1_req(dma1_req), .dma2_req(dma2_req),
    .req_status(req_status), .err(err));

  audio_fifo_req #(.IS_RX(1'b0)) dut_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(t_wr_ready), .rd_valid(t_rd_valid), .rd_data(t_rd_data), .rd_ready(rd_ready),
    .level(t_level), .irq_en(irq_en), .dma1_en(dma1_en), .dma2_en(dma2_en),
    .irq_thr(irq_thr), .dma1_thr(dma1_thr), .dma2_thr(dma2_thr),
    .irq_req(t_irq), .dma1_req(t_dma1), .dma2_req(t_dma2),
    .req_status(t_status), .err(t_err));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    int lv;
    logic [2:0] en, erx, etx;
    lv = q.size();
    en = {dma2_en, dma1_en, irq_en};
    erx = {en[2] && (lv >= int'(dma2_thr)), en[1] && (lv >= int'(dma1_thr)), en[0] && (lv >= int'(irq_thr))};
    etx = {en[2] && (lv <= int'(dma2_thr)), en[1] && (lv <= int'(dma1_thr)), en[0] && (lv <= int'(irq_thr))};
    chk("R3 level", DW'(level), DW'(lv));
    chk("R3 tx level", DW'(t_level), DW'(lv));
    chk("R3 wr_ready", DW'(wr_ready), DW'(lv != 8));
    chk("R3 rd_valid", DW'(rd_valid), DW'(lv != 0));
    chk("R4/R5 err", DW'(err), DW'(exp_err));
    if (lv != 0) chk("R2 rd_data", rd_data, q[0]);
    chk("R6 R8 rx requests", DW'({dma2_req, dma1_req, irq_req}), DW'(erx));
    chk("R7 R8 tx requests", DW'({t_dma2, t_dma1, t_irq}), DW'(etx));
    chk("R9 rx status", DW'(req_status), DW'(erx));
    chk("R9 tx status", DW'(t_status), DW'(etx));
  endtask

  task automatic step(input bit w, input logic [DW-1:0] d, input bit r, input bit f);
    bit full, empty;
    wr_valid = w; wr_data = d; rd_ready = r; flush = f;
    full = (q.size() == 8);
    empty = (q.size() == 0);
    if (f) begin
      q.delete();
      exp_err = 1'b0;
    end else begin
      exp_err = (w && full) || (r && empty);
      if (r && !empty) void'(q.pop_front());
      if (w && !full) q.push_back(d);
    end
    @(posedge clk); #2;
    wr_valid = 0; rd_ready = 0; flush = 0;
    check_all();
  endtask

  task automatic set_req(input bit e, input int ti, input int t1, input int t2);
    irq_en = e; dma1_en = e; dma2_en = e;
    irq_thr = LW'(ti); dma1_thr = LW'(t1); dma2_thr = LW'(t2);
  endtask

  task automatic t_reset();
    rst_n = 0; flush = 0; wr_valid = 0; rd_ready = 0; wr_data = '0;
    set_req(0, 0, 0, 0);
    q.delete(); exp_err = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    chk("R1 level", DW'(level), 0);
    chk("R1 wr_ready", DW'(wr_ready), 1);
    chk("R1 rd_valid", DW'(rd_valid), 0);
    chk("R1 err", DW'(err), 0);
    check_all();
  endtask

  task automatic t_fill_drain(input int ti, input int t1, input int t2);
    set_req(1, ti, t1, t2);
    for (int i = 0; i < 8; i++) step(1, 32'hA000_0000 + DW'(i * 17 + ti), 0, 0);
    for (int i = 0; i < 8; i++) step(0, '0, 1, 0);
  endtask

  task automatic t_enables_off();
    set_req(0, 0, 4, 8);
    for (int i = 0; i < 8; i++) step(1, DW'(i), 0, 0);
    chk("R8 rx irq off at full", DW'(irq_req), 0);
    irq_en = 1; #1;
    chk("R8 rx irq on when enabled", DW'(irq_req), 1);
    dma1_en = 1; #1;
    chk("R9 status bit1 is dma1", DW'(req_status), 3'b011);
    for (int i = 0; i < 8; i++) step(0, '0, 1, 0);
  endtask

  task automatic t_overflow();
    set_req(1, 8, 8, 7);
    for (int i = 0; i < 8; i++) step(1, 32'h5500_0000 + DW'(i), 0, 0);
    step(1, 32'hDEAD_BEEF, 0, 0);
    chk("R4 err pulse", DW'(err), 1);
    step(0, '0, 0, 0);
    chk("R4 err one cycle", DW'(err), 0);
    for (int i = 0; i < 8; i++) begin
      chk("R4 contents kept", rd_data, 32'h5500_0000 + DW'(i));
      step(0, '0, 1, 0);
    end
  endtask

  task automatic t_underflow();
    step(0, '0, 1, 0);
    chk("R5 err pulse", DW'(err), 1);
    chk("R5 level stays 0", DW'(level), 0);
    step(0, '0, 0, 0);
    chk("R5 err one cycle", DW'(err), 0);
  endtask

  task automatic t_flush();
    set_req(1, 2, 5, 0);
    for (int i = 0; i < 5; i++) step(1, 32'h7700_0000 + DW'(i), 0, 0);
    step(1, 32'h1234_5678, 1, 1);
    chk("R10 level zero", DW'(level), 0);
    chk("R10 no err", DW'(err), 0);
    step(1, 32'hCAFE_0001, 0, 0);
    chk("R10 first after flush", rd_data, 32'hCAFE_0001);
    step(0, '0, 1, 0);
  endtask

  task automatic t_simul();
    set_req(1, 3, 3, 3);
    for (int i = 0; i < 3; i++) step(1, 32'h3300_0000 + DW'(i), 0, 0);
    step(1, 32'h3300_0003, 1, 0);
    chk("R11 level same", DW'(level), 3);
    chk("R11 order", rd_data, 32'h3300_0001);
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0);
  endtask

  initial begin
    t_reset();
    t_fill_drain(2, 4, 6);
    t_fill_drain(0, 8, 1);
    t_enables_off();
    t_overflow();
    t_underflow();
    t_flush();
    t_simul();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule